// File: doc/BRIEF.md
# Inbound Index Register Doorbell Capture

This block sits between an external host's inbound write path and the local memory that stores a bank of index registers. The registers live inside an 8 KB messaging region whose position is programmable on any 8 KB boundary. A host write into the index part of that region goes through to memory like any other write. It also raises a doorbell: a status bit that the local processor sees as a level interrupt. The block keeps the region offset of the write that raised the doorbell, so the processor can tell which index register the host touched.

The captured offset is locked while the doorbell is pending. Software acknowledges the doorbell by writing one to the status bit, and the next host index write is then captured. Writes from the local processor to the same memory pass through untouched and never ring the doorbell. Host bursts are accepted beat by beat. A burst is captured once, at its first beat that lands in the window.

Top module: `inb_idx_capture`

## Requirements
- R1: An inbound host write hits the index window only when its upper address bits (above bit 12) equal `cfg_region` and its region offset (bits 12:0) lies in 0x050..0xFFF inclusive. Offsets 0x000..0x04F, offsets 0x1000..0x1FFF and addresses in any other region are not hits.
- R2: A host write that hits the window sets `idx_status` from the clock edge that accepts it.
- R3: When `idx_status` is clear, a hitting host write latches its 13-bit region offset into `idx_offset` at the same edge.
- R4: While `idx_status` is set and no clear is requested, `idx_offset` keeps its value across further host writes.
- R5: `sw_stat_we` with `sw_stat_wdata`=1 clears `idx_status` (write-one-to-clear). Writing 0 has no effect. `idx_offset` keeps its value through the clear until the next capture.
- R6: If a clear and a hitting host write fall in the same cycle, `idx_status` stays set and the new offset is latched.
- R7: Local-side writes (`lcl_wr_en`) never change `idx_status` or `idx_offset`.
- R8: A host beat with `host_wr_cont`=1 continues a burst. Once a beat of the current burst has been captured, later continuation beats do not change `idx_offset`. If no beat of the burst has been captured yet, the first beat that hits and is not locked out is captured.
- R9: Host and local writes reach the memory write ports one cycle later with unchanged address and data. Host reads are a combinational pass-through between `host_rd_addr`/`mem_rd_addr` and `mem_rd_data`/`host_rd_data`.
- R10: `irq` equals `idx_status` AND the mask bit. `sw_mask_we` loads the mask from `sw_mask_wdata`. Host writes outside the window still pass to memory but leave `idx_status` and `idx_offset` unchanged.
- R11: Synchronous active-low reset clears `idx_status`, the mask, `idx_offset` and both memory write enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_region | input | ADDR_W-13 | Region number (address bits above 12) of the messaging region |
| host_wr_en | input | 1 | Host write beat valid |
| host_wr_cont | input | 1 | Beat continues the current burst |
| host_wr_addr | input | ADDR_W | Host write byte address |
| host_wr_data | input | DATA_W | Host write data |
| host_rd_addr | input | ADDR_W | Host read address |
| host_rd_data | output | DATA_W | Host read data from memory |
| lcl_wr_en | input | 1 | Local processor write valid |
| lcl_wr_addr | input | ADDR_W | Local write address |
| lcl_wr_data | input | DATA_W | Local write data |
| sw_stat_we | input | 1 | Software write strobe for the status bit |
| sw_stat_wdata | input | 1 | Write-one-to-clear data for the status bit |
| sw_mask_we | input | 1 | Software write strobe for the mask bit |
| sw_mask_wdata | input | 1 | New mask value |
| idx_status | output | 1 | Pending index doorbell |
| idx_mask | output | 1 | Interrupt mask bit (1 enables) |
| idx_offset | output | 13 | Captured region offset |
| irq | output | 1 | Level interrupt to the local processor |
| mem_h_we | output | 1 | Memory host-port write enable |
| mem_h_addr | output | ADDR_W | Memory host-port address |
| mem_h_data | output | DATA_W | Memory host-port data |
| mem_l_we | output | 1 | Memory local-port write enable |
| mem_l_addr | output | ADDR_W | Memory local-port address |
| mem_l_data | output | DATA_W | Memory local-port data |
| mem_rd_addr | output | ADDR_W | Memory read address |
| mem_rd_data | input | DATA_W | Memory read data |

## Verification
The assertions assume that `host_wr_cont` is raised only on beats that follow an earlier beat of the same burst. They also assume that `cfg_region` is held steady while host writes are in flight, and that strobes and addresses carry no unknown values while a write enable is high. The stimulus changes every input on the falling clock edge, so nothing changes at the sampling edge. It programs the region once before any host traffic. The second region is reached only by changing host addresses, never by changing `cfg_region`. Every burst starts with a beat whose continuation flag is low.

// File: rtl/idxcap_pkg.sv
// Package: shared geometry of the messaging region and its index window.
// Assumes the region is 8 KB, so region offsets are 13 bits wide.
package idxcap_pkg;
    localparam int unsigned OFF_W    = 13;
    localparam logic [OFF_W-1:0] WIN_FIRST = 13'h050;
    localparam logic [OFF_W-1:0] WIN_LAST  = 13'h0FFF;
    localparam int unsigned WIN_WORDS = (int'(WIN_LAST) + 1 - int'(WIN_FIRST)) / 4;

    typedef logic [OFF_W-1:0] reg_off_t;
endpackage

// File: rtl/idxcap_decode.sv
// Module: idxcap_decode
// Decides whether a byte address lands in the index window of the
// messaging region selected by the region number. Purely combinational.
// Assumes ADDR_W > OFF_W and that the region is aligned to its own size.
module idxcap_decode
    import idxcap_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    localparam int unsigned RGN_W = ADDR_W - OFF_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [RGN_W-1:0]  region,
    output logic              hit,
    output reg_off_t          offset
);
    logic rgn_match;
    logic above_lo;
    logic below_hi;

    // Split the address and compare each part against the window bounds.
    always_comb begin
        offset    = addr[OFF_W-1:0];
        rgn_match = (addr[ADDR_W-1:OFF_W] == region);
        above_lo  = (offset >= WIN_FIRST);
        below_hi  = (offset <= WIN_LAST);
        hit       = rgn_match && above_lo && below_hi;
    end
endmodule

// File: rtl/idxcap_status.sv
// Module: idxcap_status
// Holds the doorbell status bit, the mask bit, the locked capture offset
// and the per-burst capture flag. A hit beats a same-cycle clear.
// Assumes beat_cont is high only on beats after the first of a burst.
module idxcap_status
    import idxcap_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     beat_we,
    input  logic     beat_cont,
    input  logic     beat_hit,
    input  reg_off_t beat_off,
    input  logic     clr_req,
    input  logic     mask_we,
    input  logic     mask_d,
    output logic     status,
    output logic     mask,
    output reg_off_t cap_off
);
    logic hit_wr;
    logic unlocked;
    logic burst_cap;
    logic capture;

    // Work out whether this beat rings the doorbell and whether it is captured.
    always_comb begin
        hit_wr   = beat_we && beat_hit;
        unlocked = !status || clr_req;
        capture  = hit_wr && unlocked && !(beat_cont && burst_cap);
    end

    // Status bit: a hit sets it, otherwise a write-one clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)        status <= 1'b0;
        else if (hit_wr)   status <= 1'b1;
        else if (clr_req)  status <= 1'b0;
    end

    // Mask bit loaded by software.
    always_ff @(posedge clk) begin
        if (!rst_n)        mask <= 1'b0;
        else if (mask_we)  mask <= mask_d;
    end

    // Captured offset updated only on an unlocked capture.
    always_ff @(posedge clk) begin
        if (!rst_n)        cap_off <= '0;
        else if (capture)  cap_off <= beat_off;
    end

    // Remember whether the running burst has already been captured.
    always_ff @(posedge clk) begin
        if (!rst_n)                     burst_cap <= 1'b0;
        else if (capture)               burst_cap <= 1'b1;
        else if (beat_we && !beat_cont) burst_cap <= 1'b0;
    end

    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        status && !clr_req |=> $stable(cap_off)); // R4
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        hit_wr && clr_req |=> status); // R6
    AST_HIT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        hit_wr |=> status); // R2
    AST_NO_HIT_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_wr && !status |=> !status); // R7
    AST_BURST_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        beat_we && beat_cont && burst_cap |=> $stable(cap_off)); // R8
endmodule

// File: rtl/idxcap_mempath.sv
// Module: idxcap_mempath
// Registers the host and local write channels toward the backing memory
// and passes host reads straight through. Holds no register contents.
// Assumes the memory accepts one write per port per cycle.
module idxcap_mempath #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_we,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic [DATA_W-1:0] h_data,
    input  logic              l_we,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_data,
    input  logic [ADDR_W-1:0] rd_addr_in,
    output logic [DATA_W-1:0] rd_data_out,
    output logic              mh_we,
    output logic [ADDR_W-1:0] mh_addr,
    output logic [DATA_W-1:0] mh_data,
    output logic              ml_we,
    output logic [ADDR_W-1:0] ml_addr,
    output logic [DATA_W-1:0] ml_data,
    output logic [ADDR_W-1:0] mrd_addr,
    input  logic [DATA_W-1:0] mrd_data
);
    // Host write stage toward memory.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mh_we   <= 1'b0;
            mh_addr <= '0;
            mh_data <= '0;
        end else begin
            mh_we   <= h_we;
            mh_addr <= h_addr;
            mh_data <= h_data;
        end
    end

    // Local write stage toward memory.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ml_we   <= 1'b0;
            ml_addr <= '0;
            ml_data <= '0;
        end else begin
            ml_we   <= l_we;
            ml_addr <= l_addr;
            ml_data <= l_data;
        end
    end

    // Read path passes through unchanged.
    always_comb begin
        mrd_addr    = rd_addr_in;
        rd_data_out = mrd_data;
    end

    AST_HOST_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        h_we |=> mh_we && mh_addr == $past(h_addr) && mh_data == $past(h_data)); // R9
    AST_LOCAL_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        l_we |=> ml_we && ml_addr == $past(l_addr)); // R9
endmodule

// File: rtl/inb_idx_capture.sv
// Module: inb_idx_capture (top)
// Watches host writes for index-window hits, rings a maskable doorbell,
// captures the first hit's region offset and forwards all traffic to memory.
// Assumes cfg_region is stable while host traffic is in flight.
module inb_idx_capture
    import idxcap_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned RGN_W = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RGN_W-1:0]  cfg_region,
    input  logic              host_wr_en,
    input  logic              host_wr_cont,
    input  logic [ADDR_W-1:0] host_wr_addr,
    input  logic [DATA_W-1:0] host_wr_data,
    input  logic [ADDR_W-1:0] host_rd_addr,
    output logic [DATA_W-1:0] host_rd_data,
    input  logic              lcl_wr_en,
    input  logic [ADDR_W-1:0] lcl_wr_addr,
    input  logic [DATA_W-1:0] lcl_wr_data,
    input  logic              sw_stat_we,
    input  logic              sw_stat_wdata,
    input  logic              sw_mask_we,
    input  logic              sw_mask_wdata,
    output logic              idx_status,
    output logic              idx_mask,
    output logic [OFF_W-1:0]  idx_offset,
    output logic              irq,
    output logic              mem_h_we,
    output logic [ADDR_W-1:0] mem_h_addr,
    output logic [DATA_W-1:0] mem_h_data,
    output logic              mem_l_we,
    output logic [ADDR_W-1:0] mem_l_addr,
    output logic [DATA_W-1:0] mem_l_data,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [DATA_W-1:0] mem_rd_data
);
    logic     win_hit;
    reg_off_t win_off;
    logic     clr_req;

    // Software clear is a write of one to the status bit.
    always_comb clr_req = sw_stat_we && sw_stat_wdata;

    idxcap_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr   (host_wr_addr),
        .region (cfg_region),
        .hit    (win_hit),
        .offset (win_off)
    );

    idxcap_status u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .beat_we   (host_wr_en),
        .beat_cont (host_wr_cont),
        .beat_hit  (win_hit),
        .beat_off  (win_off),
        .clr_req   (clr_req),
        .mask_we   (sw_mask_we),
        .mask_d    (sw_mask_wdata),
        .status    (idx_status),
        .mask      (idx_mask),
        .cap_off   (idx_offset)
    );

    idxcap_mempath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk         (clk),
        .rst_n       (rst_n),
        .h_we        (host_wr_en),
        .h_addr      (host_wr_addr),
        .h_data      (host_wr_data),
        .l_we        (lcl_wr_en),
        .l_addr      (lcl_wr_addr),
        .l_data      (lcl_wr_data),
        .rd_addr_in  (host_rd_addr),
        .rd_data_out (host_rd_data),
        .mh_we       (mem_h_we),
        .mh_addr     (mem_h_addr),
        .mh_data     (mem_h_data),
        .ml_we       (mem_l_we),
        .ml_addr     (mem_l_addr),
        .ml_data     (mem_l_data),
        .mrd_addr    (mem_rd_addr),
        .mrd_data    (mem_rd_data)
    );

    // Level interrupt toward the local processor.
    always_comb irq = idx_status && idx_mask;

    AST_OUTSIDE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !idx_status && !(host_wr_en && host_wr_addr[ADDR_W-1:OFF_W] == cfg_region)
        |=> !idx_status); // R10
    AST_CAPTURE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        !idx_status && host_wr_en && win_hit |=> idx_offset == $past(host_wr_addr[OFF_W-1:0])); // R3
    AST_LOCAL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        lcl_wr_en && !host_wr_en |=> $stable(idx_offset)); // R7
endmodule

// File: tb/sim_inb_idx_capture.sv
module sim_inb_idx_capture;
    localparam int unsigned AW = 32;
    localparam int unsigned DW = 32;
    localparam logic [AW-1:0] BASE = 32'h8000_4000;
    localparam logic [AW-1:0] ALT  = 32'h8000_6000;

    typedef struct packed {
        logic        hw;
        logic        alt;
        logic [12:0] hoff;
        logic        cont;
        logic        clr;
        logic        lw;
        logic [12:0] loff;
        logic        est;
        logic [12:0] eoff;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        '{1'b1,1'b0,13'h040,1'b0,1'b0,1'b0,13'h000,1'b0,13'h000}, // R1 R10 below window
        '{1'b0,1'b0,13'h000,1'b0,1'b0,1'b1,13'h100,1'b0,13'h000}, // R7 local write
        '{1'b1,1'b0,13'h100,1'b0,1'b0,1'b0,13'h000,1'b1,13'h100}, // R2 R3 capture
        '{1'b1,1'b0,13'h200,1'b0,1'b0,1'b1,13'h300,1'b1,13'h100}, // R4 locked
        '{1'b0,1'b0,13'h000,1'b0,1'b1,1'b0,13'h000,1'b0,13'h100}, // R5 clear keeps offset
        '{1'b1,1'b0,13'h04C,1'b0,1'b0,1'b0,13'h000,1'b0,13'h100}, // R1 last below
        '{1'b1,1'b0,13'h050,1'b0,1'b0,1'b0,13'h000,1'b1,13'h050}, // R1 first in window
        '{1'b1,1'b0,13'h0FFC,1'b0,1'b1,1'b0,13'h000,1'b1,13'h0FFC}, // R6 set wins
        '{1'b0,1'b0,13'h000,1'b0,1'b1,1'b0,13'h000,1'b0,13'h0FFC}, // R5 clear
        '{1'b1,1'b0,13'h1000,1'b0,1'b0,1'b0,13'h000,1'b0,13'h0FFC}, // R1 above window
        '{1'b1,1'b0,13'h300,1'b0,1'b0,1'b0,13'h000,1'b1,13'h300}, // R8 burst head
        '{1'b1,1'b0,13'h304,1'b1,1'b1,1'b0,13'h000,1'b1,13'h300}, // R8 tail with clear
        '{1'b0,1'b0,13'h000,1'b0,1'b1,1'b0,13'h000,1'b0,13'h300}, // R5 clear
        '{1'b1,1'b1,13'h100,1'b0,1'b0,1'b0,13'h000,1'b0,13'h300}, // R1 other region
        '{1'b1,1'b0,13'h048,1'b0,1'b0,1'b0,13'h000,1'b0,13'h300}, // R8 burst starts outside
        '{1'b1,1'b0,13'h04C,1'b1,1'b0,1'b0,13'h000,1'b0,13'h300}, // R8 still outside
        '{1'b1,1'b0,13'h050,1'b1,1'b0,1'b0,13'h000,1'b1,13'h050}  // R8 first hit captured
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_wr_en = 1'b0, host_wr_cont = 1'b0;
    logic [AW-1:0] host_wr_addr = '0, host_rd_addr = '0, lcl_wr_addr = '0;
    logic [DW-1:0] host_wr_data = '0, lcl_wr_data = '0, mem_rd_data = '0;
    logic lcl_wr_en = 1'b0, sw_stat_we = 1'b0, sw_stat_wdata = 1'b0;
    logic sw_mask_we = 1'b0, sw_mask_wdata = 1'b0;
    logic [DW-1:0] host_rd_data, mem_h_data, mem_l_data;
    logic [AW-1:0] mem_h_addr, mem_l_addr, mem_rd_addr;
    logic idx_status, idx_mask, irq, mem_h_we, mem_l_we;
    logic [12:0] idx_offset;
    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    inb_idx_capture #(.ADDR_W(AW), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_region(BASE[AW-1:13]),
        .host_wr_en(host_wr_en), .host_wr_cont(host_wr_cont),
        .host_wr_addr(host_wr_addr), .host_wr_data(host_wr_data),
        .host_rd_addr(host_rd_addr), .host_rd_data(host_rd_data),
        .lcl_wr_en(lcl_wr_en), .lcl_wr_addr(lcl_wr_addr), .lcl_wr_data(lcl_wr_data),
        .sw_stat_we(sw_stat_we), .sw_stat_wdata(sw_stat_wdata),
        .sw_mask_we(sw_mask_we), .sw_mask_wdata(sw_mask_wdata),
        .idx_status(idx_status), .idx_mask(idx_mask), .idx_offset(idx_offset), .irq(irq),
        .mem_h_we(mem_h_we), .mem_h_addr(mem_h_addr), .mem_h_data(mem_h_data),
        .mem_l_we(mem_l_we), .mem_l_addr(mem_l_addr), .mem_l_data(mem_l_data),
        .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        host_wr_en = 0; host_wr_cont = 0; lcl_wr_en = 0;
        sw_stat_we = 0; sw_stat_wdata = 0; sw_mask_we = 0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step(); step();
        check("R11 status after reset", 32'(idx_status), 0);
        check("R11 offset after reset", 32'(idx_offset), 0);
        check("R11 mask after reset", 32'(idx_mask), 0);
        check("R11 mem enable after reset", 32'(mem_h_we), 0);
        rst_n = 1;
        step();

        for (int i = 0; i < NV; i++) begin
            host_wr_en   = VEC[i].hw;
            host_wr_addr = (VEC[i].alt ? ALT : BASE) + 32'(VEC[i].hoff);
            host_wr_data = 32'hD000_0000 + 32'(i);
            host_wr_cont = VEC[i].cont;
            sw_stat_we   = VEC[i].clr;
            sw_stat_wdata = VEC[i].clr;
            lcl_wr_en    = VEC[i].lw;
            lcl_wr_addr  = BASE + 32'(VEC[i].loff);
            step();
            check($sformatf("R1/R2/R3/R4/R5/R6/R7/R8 status vec %0d", i), 32'(idx_status), 32'(VEC[i].est));
            check($sformatf("R3/R4/R5/R6/R8 offset vec %0d", i), 32'(idx_offset), 32'(VEC[i].eoff));
            check($sformatf("R9 mem host enable vec %0d", i), 32'(mem_h_we), 32'(VEC[i].hw));
            if (VEC[i].hw)
                check($sformatf("R9 mem host data vec %0d", i), mem_h_data, 32'hD000_0000 + 32'(i));
            idle();
        end

        // R5: writing zero to the status bit does not clear it
        check("R5 status set before zero write", 32'(idx_status), 1);
        sw_stat_we = 1; sw_stat_wdata = 0;
        step(); idle();
        check("R5 zero write keeps status", 32'(idx_status), 1);

        // R10: interrupt follows status only when masked in
        check("R10 irq masked off", 32'(irq), 0);
        sw_mask_we = 1; sw_mask_wdata = 1;
        step(); idle();
        check("R10 irq enabled", 32'(irq), 1);
        sw_stat_we = 1; sw_stat_wdata = 1;
        step(); idle();
        check("R10 irq drops on clear", 32'(irq), 0);

        // R9: local and read pass-through
        lcl_wr_en = 1; lcl_wr_addr = BASE + 32'h200; lcl_wr_data = 32'h1234_5678;
        step(); idle();
        check("R9 local mem enable", 32'(mem_l_we), 1);
        check("R9 local mem address", mem_l_addr, BASE + 32'h200);
        check("R9 local mem data", mem_l_data, 32'h1234_5678);
        check("R7 local write leaves status", 32'(idx_status), 0);
        host_rd_addr = BASE + 32'h0ABC; mem_rd_data = 32'hCAFE_F00D;
        #1;
        check("R9 read address", mem_rd_addr, BASE + 32'h0ABC);
        check("R9 read data", host_rd_data, 32'hCAFE_F00D);

        // R11: reset mid-state clears everything
        host_wr_en = 1; host_wr_addr = BASE + 32'h400;
        step(); idle();
        check("R2 set before reset", 32'(idx_status), 1);
        rst_n = 0;
        step();
        check("R11 reset status", 32'(idx_status), 0);
        check("R11 reset offset", 32'(idx_offset), 0);
        check("R11 reset mask", 32'(idx_mask), 0);
        rst_n = 1;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule